// File: doc/BRIEF.md
# AES Column Mixer with Shared Forward/Inverse Network

This block applies the AES column-mixing step, or its inverse, to a whole cipher state in a single combinational pass. Each 32-bit column is read as a four-term polynomial whose coefficients are bytes in GF(2^8). The column is multiplied by a fixed coefficient polynomial, and the product is reduced modulo x^4 + 1. One mode input picks the direction for every column at once. Its intended place is the round datapath of a cipher core that runs encryption and decryption on the same hardware.

The inverse transform has no multiplier network of its own. The inverse polynomial factors into the forward polynomial times a sparse correction term, {04}x^2 + {05}, and that term is the square of the forward polynomial. In inverse mode, each column therefore first passes through a small correction stage built from doubling steps and XORs. It then enters the same forward network that encryption uses. In forward mode, a multiplexer routes the column around the correction stage without changing it. A thin top holds a mode decoder, which turns the mode bit into a pair of select strobes, and a datapath with one mixer per column.

Top module: `mixcol_unit`

## Requirements
- R1: With `invMode` = 0, each output column byte r_i equals {02}·a_i ⊕ {03}·a_(i+1) ⊕ a_(i+2) ⊕ a_(i+3), with indices mod 4. Products are in GF(2^8) reduced by 0x11B.
- R2: With `invMode` = 1, each output column byte r_i equals {0e}·a_i ⊕ {0b}·a_(i+1) ⊕ {0d}·a_(i+2) ⊕ {09}·a_(i+3), with indices mod 4.
- R3: For any state, applying the inverse mode to the forward-mode result gives back the original state.
- R4: Column c occupies bits [127-32c -: 32] of the state, and row 0 of a column is its most significant byte. Each column is transformed independently, so a column that is zero at the input is zero at the output, whatever the other columns hold.
- R5: The column 0xdb135345 maps to 0x8e4da1bc, 0xf20a225c maps to 0x9fdc589d, and 0xd4bf5d30 maps to 0x046681e5 in forward mode. Inverse mode maps each of these results back to its input.
- R6: A column whose four bytes are equal passes through unchanged in both modes.
- R7: An all-zero state gives an all-zero output in both modes.
- R8: The output follows the mode input with no clock delay. Toggling `invMode` with the state held changes the output between the forward and inverse results of that same state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| invMode | input | 1 | 0 selects the forward mix, 1 selects the inverse mix |
| stateIn | input | 32*NCOL | Input state, with column 0 in the most significant 32 bits |
| stateOut | output | 32*NCOL | Mixed state, in the same column and byte layout as the input |

## Verification
On every evaluation, the assertions check three things. First, the XOR of the four output bytes of each column equals the XOR of its input bytes in both modes, because each coefficient set sums to {01]. Second, the correction stage keeps that same parity. Third, equal-byte and all-zero columns come out unchanged, and the two select strobes are exactly one-hot. The correct coefficient placement, the reduction constant, the column and byte ordering, and the round trip from forward to inverse cannot be seen in those invariants. Only the bench's known vectors and its comparisons against a GF(2^8) model over random states can show them.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;
  localparam int BYTE_W = 8;
  localparam int ROWS   = 4;
  localparam int COL_W  = BYTE_W * ROWS;
  localparam logic [BYTE_W-1:0] REDUCE = 8'h1b;

  typedef logic [BYTE_W-1:0] byte_t;

  // Strobes from the mode decoder to the datapath.
  typedef struct packed {
    logic preEn;   // route the column through the correction stage
    logic bypass;  // route the column straight to the forward network
  } mix_strobe_t;

  // Multiply by {02}: shift left, fold the carry back with the field polynomial.
  function automatic byte_t xtime(input byte_t a);
    return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? REDUCE : '0);
  endfunction

  function automatic byte_t times4(input byte_t a);
    return xtime(xtime(a));
  endfunction

  // XOR of all bytes in a column.
  function automatic byte_t colParity(input logic [COL_W-1:0] col);
    byte_t p;
    p = '0;
    for (int i = 0; i < ROWS; i++) p ^= col[i*BYTE_W +: BYTE_W];
    return p;
  endfunction
endpackage

// File: rtl/mix_ctrl.sv
module mix_ctrl
  import mixcol_pkg::*;
(
  input  logic        invMode,
  output mix_strobe_t strb
);
  always_comb begin
    strb.preEn  = invMode;
    strb.bypass = ~invMode;
  end
endmodule

// File: rtl/col_premul.sv
// Multiplies one column by d(x) = {04}x^2 + {05}: b_i = {05}a_i ^ {04}a_(i+2).
module col_premul
  import mixcol_pkg::*;
(
  input  logic [COL_W-1:0] colIn,
  output logic [COL_W-1:0] colOut
);
  byte_t a [ROWS];
  byte_t b [ROWS];

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign a[i] = colIn[COL_W-1-BYTE_W*i -: BYTE_W];
    // {05}a_i ^ {04}a_(i+2) = {04}(a_i ^ a_(i+2)) ^ a_i
    assign b[i] = times4(a[i] ^ a[(i+2)%ROWS]) ^ a[i];
    assign colOut[COL_W-1-BYTE_W*i -: BYTE_W] = b[i];
  end

  // R2: the correction coefficients sum to {01}, so column parity survives.
  always_comb begin
    if (!$isunknown(colIn))
      p_pre_parity_r2: assert (colParity(colOut) == colParity(colIn))
        else $error("correction stage changed column parity");
  end
endmodule

// File: rtl/col_fwd_mix.sv
// Forward mix of one column: r_i = {02}a_i ^ {03}a_(i+1) ^ a_(i+2) ^ a_(i+3).
module col_fwd_mix
  import mixcol_pkg::*;
(
  input  logic [COL_W-1:0] colIn,
  output logic [COL_W-1:0] colOut
);
  byte_t a [ROWS];
  byte_t r [ROWS];

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign a[i] = colIn[COL_W-1-BYTE_W*i -: BYTE_W];
    // {02}(a_i ^ a_(i+1)) ^ a_(i+1) ^ a_(i+2) ^ a_(i+3)
    assign r[i] = xtime(a[i] ^ a[(i+1)%ROWS]) ^ a[(i+1)%ROWS]
                ^ a[(i+2)%ROWS] ^ a[(i+3)%ROWS];
    assign colOut[COL_W-1-BYTE_W*i -: BYTE_W] = r[i];
  end

  // R6: a column with four equal bytes is a fixed point of the forward mix.
  always_comb begin
    if (!$isunknown(colIn) && a[0] == a[1] && a[1] == a[2] && a[2] == a[3])
      p_const_fixed_r6: assert (colOut == colIn)
        else $error("equal-byte column was altered");
  end
endmodule

// File: rtl/mix_datapath.sv
module mix_datapath
  import mixcol_pkg::*;
#(
  parameter int NCOL = 4
) (
  input  mix_strobe_t              strb,
  input  logic [NCOL*COL_W-1:0]    stateIn,
  output logic [NCOL*COL_W-1:0]    stateOut
);
  localparam int STATE_W = NCOL * COL_W;

  // R8: exactly one path is selected at any time.
  always_comb begin
    if (!$isunknown(strb))
      p_strobe_onehot_r8: assert ($onehot({strb.preEn, strb.bypass}))
        else $error("mode strobes not one-hot");
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [COL_W-1:0] colIn, preOut, fwdIn, colOut;

    assign colIn = stateIn[STATE_W-1-COL_W*c -: COL_W];

    col_premul u_pre (.colIn(colIn), .colOut(preOut));

    assign fwdIn = strb.bypass ? colIn : preOut;

    col_fwd_mix u_fwd (.colIn(fwdIn), .colOut(colOut));

    assign stateOut[STATE_W-1-COL_W*c -: COL_W] = colOut;

    always_comb begin
      if (!$isunknown({strb, colIn})) begin
        // R1: forward coefficients sum to {01}, so column parity is kept.
        if (strb.bypass)
          p_fwd_parity_r1: assert (colParity(colOut) == colParity(colIn))
            else $error("forward mix changed column parity");
        // R2: inverse coefficients also sum to {01}.
        if (strb.preEn)
          p_inv_parity_r2: assert (colParity(colOut) == colParity(colIn))
            else $error("inverse mix changed column parity");
        // R7: zero column in, zero column out.
        if (colIn == '0)
          p_zero_col_r7: assert (colOut == '0)
            else $error("zero column produced nonzero output");
      end
    end
  end
endmodule

// File: rtl/mixcol_unit.sv
module mixcol_unit
  import mixcol_pkg::*;
#(
  parameter int NCOL = 4
) (
  input  logic                  invMode,
  input  logic [NCOL*32-1:0]    stateIn,
  output logic [NCOL*32-1:0]    stateOut
);
  mix_strobe_t strb;

  mix_ctrl u_ctrl (.invMode(invMode), .strb(strb));

  mix_datapath #(.NCOL(NCOL)) u_dp (
    .strb    (strb),
    .stateIn (stateIn),
    .stateOut(stateOut)
  );
endmodule

// File: tb/mixcol_unit_tb_top.sv
`timescale 1ns/1ps
module mixcol_unit_tb_top;
  localparam int NCOL = 4;
  localparam int SW   = NCOL * 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          invMode = 1'b0;
  logic [SW-1:0] stateIn = '0;
  logic [SW-1:0] stateOut;

  always #10 clk = ~clk;  // 50 MHz

  mixcol_unit #(.NCOL(NCOL)) dut_i (
    .invMode (invMode),
    .stateIn (stateIn),
    .stateOut(stateOut)
  );

  typedef struct {
    logic          inv;
    logic [SW-1:0] st;
    logic [SW-1:0] exp;
    string         tag;
  } item_t;

  item_t q[$];
  item_t cur;
  int    total = 0;
  int    failed = 0;
  bit    done = 0;

  // ---------------- reference model ----------------
  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = '0;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) p ^= a;
      a = a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
    end
    return p;
  endfunction

  function automatic logic [31:0] colModel(input logic [31:0] col, input logic inv);
    logic [7:0] a [4];
    logic [7:0] cf [4];
    logic [7:0] r;
    logic [31:0] res = '0;
    for (int i = 0; i < 4; i++) a[i] = col[31-8*i -: 8];
    if (inv) begin cf[0]=8'h0e; cf[1]=8'h0b; cf[2]=8'h0d; cf[3]=8'h09; end
    else     begin cf[0]=8'h02; cf[1]=8'h03; cf[2]=8'h01; cf[3]=8'h01; end
    for (int i = 0; i < 4; i++) begin
      r = '0;
      for (int j = 0; j < 4; j++) r ^= gmul(a[j], cf[(j-i+4)%4]);
      res[31-8*i -: 8] = r;
    end
    return res;
  endfunction

  function automatic logic [SW-1:0] stateModel(input logic [SW-1:0] st, input logic inv);
    logic [SW-1:0] res;
    for (int c = 0; c < NCOL; c++)
      res[SW-1-32*c -: 32] = colModel(st[SW-1-32*c -: 32], inv);
    return res;
  endfunction

  // ---------------- driver ----------------
  task automatic drive(input logic inv, input logic [SW-1:0] st,
                       input logic [SW-1:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    invMode = inv;
    stateIn = st;
    it.inv = inv; it.st = st; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  // ---------------- monitor ----------------
  always @(posedge clk) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      total++;
      if (stateOut !== cur.exp) begin
        failed++;
        $display("FAIL %s inv=%0b in=%h got=%h exp=%h",
                 cur.tag, cur.inv, cur.st, stateOut, cur.exp);
      end
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [SW-1:0] x, y;
    // Reset window: zero state in both modes (R7)
    drive(1'b0, '0, '0, "R7 zero fwd during reset");
    drive(1'b1, '0, '0, "R7 zero inv during reset");
    @(negedge clk); rst = 1'b0;

    // Known vectors (R5), with equal-byte columns (R6)
    x = {32'hdb135345, 32'hf20a225c, 32'h01010101, 32'hc6c6c6c6};
    y = {32'h8e4da1bc, 32'h9fdc589d, 32'h01010101, 32'hc6c6c6c6};
    drive(1'b0, x, y, "R5 known vectors fwd");
    drive(1'b1, y, x, "R5 known vectors inv");
    x = {32'hd4bf5d30, 32'h00000000, 32'hffffffff, 32'h80808080};
    y = {32'h046681e5, 32'h00000000, 32'hffffffff, 32'h80808080};
    drive(1'b0, x, y, "R5 d4bf5d30 fwd");
    drive(1'b1, y, x, "R5 046681e5 inv");
    drive(1'b1, {32'h2d2d2d2d, 32'h7f7f7f7f, 32'h1b1b1b1b, 32'hfefefefe},
                {32'h2d2d2d2d, 32'h7f7f7f7f, 32'h1b1b1b1b, 32'hfefefefe},
          "R6 equal-byte columns inv");

    // Column independence (R4): one nonzero column at a time
    for (int c = 0; c < NCOL; c++) begin
      x = '0;
      x[SW-1-32*c -: 32] = 32'h80a5017e;
      drive(1'b0, x, stateModel(x, 1'b0), "R4 single column fwd");
      drive(1'b1, x, stateModel(x, 1'b1), "R4 single column inv");
    end

    // Random states: forward (R1), inverse (R2), round trip (R3),
    // and mode toggling on a held state (R8)
    for (int n = 0; n < 40; n++) begin
      x = {$urandom, $urandom, $urandom, $urandom};
      y = stateModel(x, 1'b0);
      drive(1'b0, x, y, "R1 random fwd");
      drive(1'b1, y, x, "R3 round trip inv(fwd(x))");
      drive(1'b1, x, stateModel(x, 1'b1), "R2 random inv");
      drive(1'b0, x, y, "R8 mode toggle back to fwd");
    end

    // High-bit-heavy bytes stress the reduction (R1, R2)
    for (int n = 0; n < 8; n++) begin
      x = {$urandom, $urandom, $urandom, $urandom} | {NCOL*4{8'h80}};
      drive(1'b0, x, stateModel(x, 1'b0), "R1 msb-set fwd");
      drive(1'b1, x, stateModel(x, 1'b1), "R2 msb-set inv");
    end

    drive(1'b0, '0, '0, "R7 zero fwd after run");
    @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule